// File: doc/BRIEF.md
# Rollover-Aligned Serial Byte Transmitter

This block turns a byte written by a host into a ten-bit asynchronous serial frame on a single output line. The frame is a low start bit, the eight data bits least significant first, and a high stop bit. All bit timing comes from a free-running divide-by-16 counter that advances on a 16x oversampling tick input. A bit boundary is a rollover of that counter. The write itself only arms the transmitter, so every frame starts on the counter's bit grid and not at the moment of the write.

The byte goes into a shift register one position wider than the data. A marker 1 sits in the extra top position. The register shifts right with zero fill, and when the marker stands just left of the last data bit with only zeros above it, the controller makes one final shift and closes the frame. A sticky done flag then tells the host that the line is free. Writes made while a frame is armed or in flight are dropped.

Top module: `mktx_uart_tx`

## Requirements
- R1: After reset the line output is 1, busy is 0 and done is 0.
- R2: A frame is one start bit of 0, then data bits 0 through 7 in that order, then a stop bit of 1. The stop bit is the idle level, held for at least one full bit time before any later start bit.
- R3: An accepted write sets busy on the next clock edge. The line stays 1 until the first counter rollover strictly after the write cycle, and the start bit begins on that rollover. This holds even when the write cycle is itself a rollover cycle.
- R4: The divider advances only on clock edges where the tick input is 1. A rollover is the 16th tick of each counter period, and the counter runs free of writes and frames.
- R5: Data bit k (k = 0..7) appears on the line at rollover k+2 after the write and stays constant until the next rollover.
- R6: At rollover 10 after the write, busy falls to 0, done rises to 1 and the line returns to 1.
- R7: A write while busy is 1 is ignored. The frame in flight still carries the first byte, and busy and done are not disturbed.
- R8: Done stays at 1 across idle rollovers and falls to 0 on the clock edge that accepts a new write.
- R9: A write accepted on the edge right after done is set starts its frame one rollover later, so back-to-back frames keep a full stop bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Oversampling tick, 16 per bit time |
| wr_i | input | 1 | Host write strobe for one cycle |
| wr_byte_i | input | DW (8) | Byte to transmit |
| txd_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | A frame is armed or in flight |
| done_o | output | 1 | Sticky frame-complete flag |

## Verification
The bench watches for a frame that starts at the write rather than on the next rollover. It pays most attention to a write that lands on a rollover cycle itself, where a wrong design would emit a start bit that is 16 ticks too short. It checks the all-zero and all-one bytes and single set bits at each end of the byte, where a marker test that looks at the wrong position would stop one bit early or late, drop the top data bit or send a stretched stop bit. Writes are poked in during the wait state and in mid-frame to catch a design that reloads the shifter and corrupts the byte in flight. A write placed right after completion checks that the stop bit still lasts a full bit time.

// File: rtl/mktx_pkg.sv
`timescale 1ns/1ps
package mktx_pkg;

   // Frame sequencing states of the controller
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_START = 2'd2,
      ST_DATA  = 2'd3
   } tx_state_e;

endpackage

// File: rtl/mktx_divider.sv
`timescale 1ns/1ps
module mktx_divider #(
   parameter int OVS = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   output logic roll_o
);
   localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);

   if (OVS < 2) begin : g_bad_ovs
      $error("mktx_divider: OVS must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   if (OVS == (1 << CW)) begin : g_pow2
      // power of two: natural wrap of the counter
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     cnt_q <= '0;
         else if (tick_i) cnt_q <= cnt_q + CW'(1);
      end
   end else begin : g_cmp
      // arbitrary ratio: explicit wrap compare
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     cnt_q <= '0;
         else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
      end
   end

   assign roll_o = tick_i && (cnt_q == LAST);

   // R4
   cnt_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q != $past(cnt_q)) |-> $past(tick_i));

endmodule

// File: rtl/mktx_shifter.sv
`timescale 1ns/1ps
module mktx_shifter #(
   parameter int DW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic          shift_i,
   input  logic [DW-1:0] data_i,
   output logic          bit0_o,
   output logic          last_o,
   output logic [DW:0]   sh_o
);
   localparam int SW = DW + 1;

   logic [SW-1:0] sh_q;

   // reset content: marker alone at the output position
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sh_q <= SW'(1);
      else if (load_i)   sh_q <= {1'b1, data_i};
      else if (shift_i)  sh_q <= {1'b0, sh_q[SW-1:1]};
   end

   assign bit0_o = sh_q[0];
   // marker sits just left of the output bit, zeros beyond it
   assign last_o = (sh_q[SW-1:1] == DW'(1));
   assign sh_o   = sh_q;

   // R2
   zero_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shift_i && !load_i) |=> !sh_q[SW-1]);

endmodule

// File: rtl/mktx_ctrl.sv
`timescale 1ns/1ps
module mktx_ctrl
   import mktx_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic roll_i,
   input  logic wr_i,
   input  logic last_i,
   output logic load_o,
   output logic shift_o,
   output logic send_o,
   output logic den_o,
   output logic busy_o,
   output logic done_o
);
   tx_state_e st_q, st_d;
   logic      done_q;
   logic      accept;
   logic      finish;

   assign accept = wr_i && (st_q == ST_IDLE);
   assign finish = roll_i && (st_q == ST_DATA) && last_i;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:  if (accept) st_d = ST_ARMED;
         ST_ARMED: if (roll_i) st_d = ST_START;
         ST_START: if (roll_i) st_d = ST_DATA;
         ST_DATA:  if (finish) st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         done_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (accept)      done_q <= 1'b0;
         else if (finish) done_q <= 1'b1;
      end
   end

   assign load_o  = accept;
   assign shift_o = roll_i && (st_q == ST_DATA);
   assign send_o  = (st_q == ST_START) || (st_q == ST_DATA);
   assign den_o   = (st_q == ST_DATA);
   assign busy_o  = (st_q != ST_IDLE);
   assign done_o  = done_q;

   // R5
   hold_between_rolls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!roll_i && st_q != ST_IDLE) |=> (st_q == $past(st_q)));

   // R6
   done_on_roll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_q) |-> $past(roll_i));

   // R8
   done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept |=> !done_q);

   // R3
   armed_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept |=> (st_q == ST_ARMED));

endmodule

// File: rtl/mktx_uart_tx.sv
`timescale 1ns/1ps
module mktx_uart_tx #(
   parameter int DW      = 8,
   parameter int OVS     = 16,
   parameter bit OUT_REG = 1'b0
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          tick16_i,
   input  logic          wr_i,
   input  logic [DW-1:0] wr_byte_i,
   output logic          txd_o,
   output logic          busy_o,
   output logic          done_o
);
   localparam int SW = DW + 1;

   if (DW < 2) begin : g_bad_dw
      $error("mktx_uart_tx: DW must be at least 2");
   end

   logic          roll;
   logic          load, shift, send, den, last, bit0;
   logic [SW-1:0] sh;
   logic          line_d;

   mktx_divider #(.OVS(OVS)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick16_i),
      .roll_o (roll)
   );

   mktx_shifter #(.DW(DW)) u_sh (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .shift_i (shift),
      .data_i  (wr_byte_i),
      .bit0_o  (bit0),
      .last_o  (last),
      .sh_o    (sh)
   );

   mktx_ctrl u_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .roll_i  (roll),
      .wr_i    (wr_i),
      .last_i  (last),
      .load_o  (load),
      .shift_o (shift),
      .send_o  (send),
      .den_o   (den),
      .busy_o  (busy_o),
      .done_o  (done_o)
   );

   // idle high; start bit while send without data-enable
   assign line_d = !send ? 1'b1 : (den ? bit0 : 1'b0);

   if (OUT_REG) begin : g_out_reg
      logic txd_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) txd_q <= 1'b1;
         else         txd_q <= line_d;
      end
      assign txd_o = txd_q;
   end else begin : g_out_comb
      assign txd_o = line_d;

      // R2
      idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !busy_o |-> txd_o);
   end

   // R7
   ignore_busy_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && wr_i && !roll) |=> $stable(sh));

   // R6
   marker_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> (sh != '0));

endmodule

// File: tb/mktx_uart_tx_test.sv
`timescale 1ns/1ps
module mktx_uart_tx_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] wr_byte = 8'h00;
   logic       txd, busy, done;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   int rolls = 0;
   int tk = 0;
   int ph = 0;
   bit ended = 1'b0;

   always #4 clk = ~clk;

   mktx_uart_tx uut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .tick16_i  (tick16),
      .wr_i      (wr),
      .wr_byte_i (wr_byte),
      .txd_o     (txd),
      .busy_o    (busy),
      .done_o    (done)
   );

   // tick every third cycle, changed at the falling edge
   always @(negedge clk) begin
      ph     <= (ph == 2) ? 0 : ph + 1;
      tick16 <= (ph == 1);
   end

   // bit-grid reference: 16 ticks per bit time (R4)
   always @(posedge clk) begin
      if (!rst_n) begin
         tk    <= 0;
         rolls <= 0;
      end else if (tick16) begin
         if (tk == 15) begin
            tk    <= 0;
            rolls <= rolls + 1;
         end else begin
            tk <= tk + 1;
         end
      end
   end

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
         summary();
      end
   end

   task automatic chk(input string req, input string what, input logic [7:0] act,
                      input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_roll(input int target);
      while (rolls < target) @(negedge clk);
   endtask

   task automatic do_write(input logic [7:0] b, output int r0);
      @(negedge clk); #1;
      wr = 1'b1;
      wr_byte = b;
      @(posedge clk); #1;
      r0 = rolls;
      @(negedge clk); #1;
      wr = 1'b0;
   endtask

   task automatic poke(input logic [7:0] b);
      @(negedge clk); #1;
      wr = 1'b1;
      wr_byte = b;
      @(negedge clk); #1;
      wr = 1'b0;
   endtask

   // walks rollovers r0+1 .. r0+10; poke_k > 0 injects an ignored write
   task automatic check_frame(input logic [7:0] b, input int r0, input int poke_k);
      for (int k = 1; k <= 10; k++) begin
         wait_roll(r0 + k);
         if (k == 1) chk("R2", "start bit", {7'd0, txd}, 8'd0);
         else if (k <= 9) chk("R5", "data bit", {7'd0, txd}, {7'd0, b[k-2]});
         else chk("R6", "line after frame", {7'd0, txd}, 8'd1);
         if (k < 10) begin
            chk("R6", "busy in frame", {7'd0, busy}, 8'd1);
            chk("R6", "done in frame", {7'd0, done}, 8'd0);
            repeat (20) @(negedge clk);
            chk("R5", "mid-bit hold", {7'd0, txd},
                (k == 1) ? 8'd0 : {7'd0, b[k-2]});
            if (k == poke_k) poke(~b);
         end else begin
            chk("R6", "busy end", {7'd0, busy}, 8'd0);
            chk("R6", "done end", {7'd0, done}, 8'd1);
         end
      end
   endtask

   task automatic t_reset();
      chk("R1", "txd", {7'd0, txd}, 8'd1);
      chk("R1", "busy", {7'd0, busy}, 8'd0);
      chk("R1", "done", {7'd0, done}, 8'd0);
   endtask

   task automatic t_frame(input logic [7:0] b);
      int r0;
      do_write(b, r0);
      chk("R3", "busy after write", {7'd0, busy}, 8'd1);
      chk("R3", "line before start", {7'd0, txd}, 8'd1);
      check_frame(b, r0, 0);
   endtask

   task automatic t_aligned();
      int r0;
      // place the write on a clock edge that is itself a rollover
      do begin
         @(negedge clk); #1;
      end while (!(tick16 && tk == 15));
      wr = 1'b1;
      wr_byte = 8'h96;
      @(posedge clk); #1;
      r0 = rolls;
      @(negedge clk); #1;
      wr = 1'b0;
      chk("R3", "aligned write armed", {7'd0, busy}, 8'd1);
      chk("R3", "aligned line high", {7'd0, txd}, 8'd1);
      repeat (30) @(negedge clk);
      chk("R3", "no early start", {7'd0, txd}, 8'd1);
      check_frame(8'h96, r0, 0);
   endtask

   task automatic t_ignore();
      int r0;
      do_write(8'h3C, r0);
      poke(8'hFF);   // dropped while armed
      chk("R7", "busy kept", {7'd0, busy}, 8'd1);
      check_frame(8'h3C, r0, 5);
   endtask

   task automatic t_done_hold();
      int r0;
      r0 = rolls;
      wait_roll(r0 + 2);
      @(negedge clk);
      chk("R8", "done held", {7'd0, done}, 8'd1);
      chk("R8", "line idle", {7'd0, txd}, 8'd1);
      do_write(8'h5A, r0);
      chk("R8", "done cleared", {7'd0, done}, 8'd0);
      check_frame(8'h5A, r0, 0);
   endtask

   task automatic t_b2b();
      int  r0;
      logic low_seen;
      // previous frame just ended at this negedge
      do_write(8'hE1, r0);
      low_seen = 1'b0;
      while (rolls < r0 + 1) begin
         if (txd !== 1'b1) low_seen = 1'b1;
         @(negedge clk);
      end
      chk("R9", "stop bit full length", {7'd0, low_seen}, 8'd0);
      chk("R9", "start after stop", {7'd0, txd}, 8'd0);
      check_frame(8'hE1, r0 - 0, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_frame(8'hA5);
      t_frame(8'h00);
      t_frame(8'hFF);
      t_frame(8'h01);
      t_frame(8'h80);
      t_aligned();
      t_ignore();
      t_done_hold();
      t_b2b();
      summary();
   end
endmodule